// File: doc/BRIEF.md
# Shared Vector Source Discriminator

This block sits between several pairs of interrupt event sources and the interrupt controller. Each pair shares one interrupt vector. Every source has a valid bit, and only a valid source can raise the shared request for its pair. Typical sources are a key-press wakeup, a serial bus collision detector, an ADC completion and a timer.

Each source also has a sticky discrimination flag. The flag records that the source's event occurred, whatever the valid bit says. Inside the handler, software reads the flags to learn which source of the pair fired. The flags stay set when the interrupt is accepted. Software clears them itself through a clear-only write, in which a 0 clears a bit and a 1 leaves it unchanged.

The request output carries one single-cycle pulse per pair. It drives the set input of the controller's request latch.

Top module: `shared_vec_disc`

## Requirements
- R1: After reset, the valid register and the flag register both read 0, and `vec_req` is 0.
- R2: A high `src_evt[i]` in a cycle sets flag bit i at that clock edge, whether valid bit i is 1 or 0.
- R3: If source `2p` or `2p+1` has its event while its valid bit is 1, `vec_req[p]` goes high for exactly the one cycle after that edge.
- R4: An event from a source whose valid bit is 0 leaves `vec_req` at 0.
- R5: A flag that is set stays set through any number of idle cycles and through request pulses. Nothing but a software write clears it.
- R6: A write to address 1 clears every flag bit whose `wr_data` bit is 0 and leaves every bit written as 1 unchanged.
- R7: If source i has an event in the same cycle as a write that clears flag i, flag i ends up set.
- R8: Address 0 holds the valid register and address 1 holds the flag register. Bit i of each belongs to source i, and read bits from 4 to 7 are always 0.
- R9: A write to address 0 loads `wr_data[3:0]` into the valid register.
- R10: If both sources of a pair fire valid events in the same cycle, the pair gets one single-cycle pulse and both flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt | input | 4 | Event strobes, one per source; source i belongs to pair i/2 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 = valid, 1 = flags |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| vec_req | output | 2 | Request pulse for each shared vector |

## Verification
A wrong valid bit shows at the ports one cycle after the source's event, as a request pulse that should not be there or a pulse that is missing on `vec_req`. A flag that is lost, cleared on its own or wrongly preserved shows on the next read of address 1, which is combinational and therefore visible in the same cycle. The collision of an event with a clearing write is the one ordering hazard. A design that gives the write priority shows a 0 in that bit on the very next read.

// File: rtl/shared_vec_disc.sv
module shared_vec_disc #(
  parameter int NPAIR = 2,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2*NPAIR-1:0] src_evt,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  output logic [NPAIR-1:0] vec_req
);
  localparam int NSRC = 2 * NPAIR;

  logic [NSRC-1:0]  valid_q, flag_q;
  logic [NSRC-1:0]  hit;
  logic [NPAIR-1:0] pair_hit;
  logic             wr_valid, wr_flag;

  assign wr_valid = wr_en && !addr;
  assign wr_flag  = wr_en && addr;
  assign hit      = src_evt & valid_q;

  genvar p;
  generate
    for (p = 0; p < NPAIR; p++) begin : g_pair
      assign pair_hit[p] = hit[2*p] | hit[2*p+1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      flag_q  <= '0;
      vec_req <= '0;
    end else begin
      if (wr_valid) valid_q <= wr_data[NSRC-1:0];
      flag_q  <= (flag_q & (wr_flag ? wr_data[NSRC-1:0] : {NSRC{1'b1}})) | src_evt;
      vec_req <= pair_hit;
    end
  end

  assign rd_data = {{(DW-NSRC){1'b0}}, addr ? flag_q : valid_q};

  p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((flag_q & $past(src_evt)) == $past(src_evt)));

  p_flag_rise_only_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~($past(flag_q) | $past(src_evt))) == '0));

  p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_flag && src_evt == '0) |=> $stable(flag_q));

  generate
    for (p = 0; p < NPAIR; p++) begin : g_chk
      p_req_on_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_evt[2*p] && valid_q[2*p]) || (src_evt[2*p+1] && valid_q[2*p+1]))
          |=> vec_req[p]);
      p_req_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(src_evt[2*p] && valid_q[2*p]) && !(src_evt[2*p+1] && valid_q[2*p+1]))
          |=> !vec_req[p]);
    end
  endgenerate
endmodule

// File: tb/shared_vec_disc_tb.sv
module shared_vec_disc_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic [3:0] src_evt = '0;
  logic       wr_en = 0, addr = 0;
  logic [7:0] wr_data = '0, rd_data;
  logic [1:0] vec_req;
  int n_chk = 0, n_bad = 0;

  shared_vec_disc u_dut (.clk(clk), .rst_n(rst_n), .src_evt(src_evt), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .vec_req(vec_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic pulse(logic [3:0] m);
    @(negedge clk); src_evt = m;
    @(negedge clk); src_evt = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(0, d); chk("R1 valid", d, 8'h00);
    rd(1, d); chk("R1 flags", d, 8'h00);
    chk("R1 vec_req", {6'b0, vec_req}, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(0, 8'hFA);
    rd(0, d); chk("R9 valid load", d, 8'h0A);
    chk("R8 upper zero", {4'b0, d[7:4]}, 8'h00);
    wr(0, 8'h00);
    rd(0, d); chk("R9 valid clear", d, 8'h00);
  endtask

  task automatic t_invalid;
    logic [7:0] d;
    pulse(4'b0001);
    chk("R4 no request", {6'b0, vec_req}, 8'h00);
    rd(1, d); chk("R2 flag set while invalid", d, 8'h01);
  endtask

  task automatic t_valid;
    logic [7:0] d;
    wr(0, 8'h04);
    pulse(4'b0100);
    chk("R3 pulse pair1", {6'b0, vec_req}, 8'h02);
    @(negedge clk);
    chk("R3 single cycle", {6'b0, vec_req}, 8'h00);
    rd(1, d); chk("R2 flag set valid", d, 8'h05);
  endtask

  task automatic t_persist;
    logic [7:0] d;
    repeat (6) @(negedge clk);
    rd(1, d); chk("R5 flags persist", d, 8'h05);
  endtask

  task automatic t_clear;
    logic [7:0] d;
    wr(1, 8'hFE);
    rd(1, d); chk("R6 clear bit0", d, 8'h04);
    wr(1, 8'hFF);
    rd(1, d); chk("R6 ones preserve", d, 8'h04);
    wr(1, 8'h00);
    rd(1, d); chk("R6 clear all", d, 8'h00);
  endtask

  task automatic t_race;
    logic [7:0] d;
    wr(1, 8'h00);
    @(negedge clk); wr_en = 1; addr = 1; wr_data = 8'h00; src_evt = 4'b0010;
    @(negedge clk); wr_en = 0; src_evt = '0;
    rd(1, d); chk("R7 event beats clear", d, 8'h02);
  endtask

  task automatic t_both;
    logic [7:0] d;
    wr(0, 8'h0F);
    wr(1, 8'h00);
    pulse(4'b0011);
    chk("R10 one pulse pair0", {6'b0, vec_req}, 8'h01);
    @(negedge clk);
    chk("R10 pulse ends", {6'b0, vec_req}, 8'h00);
    rd(1, d); chk("R10 both flags", d, 8'h03);
    rd(0, d); chk("R8 valid map", d, 8'h0F);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_regs;
    t_invalid;
    t_valid;
    t_persist;
    t_clear;
    t_race;
    t_both;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule